// File: doc/BRIEF.md
# Management Data Register with Emulated PHY

This block gives a host one 32-bit management word through which it reaches a set of emulated PHY register files. A host write loads the whole word at once. When the opcode field of the written word asks for a write, the data field goes into the PHY register that the PHY-address and register-address fields of that same word select. A management access therefore completes in the cycle it is issued. No serial management pins are driven.

The host reads the word back combinationally on `host_rdata`. The ready flag in that word always reads as set. When the stored opcode asks for a read, the data field is replaced by the value of the addressed PHY register. A read strobe with that opcode also writes the fetched value into the stored word. The PHY model returns fixed identity and capability values for a handful of registers. Register 0 is shaped on readback. All other registers return what was last written.

The number of emulated PHY addresses is a parameter. Addresses beyond it read as zero and drop writes.

Top module: `mdi_mgmt_reg`

## Requirements
- R1: After reset the word reads 0x1000_0000, and every emulated PHY register holds zero: through a read opcode, register 4 returns 0x0000 and register 0 returns 0x2000.
- R2: A host write loads all 32 bits of the word. A later read returns that word with bit 28 (ready) forced to 1, whatever was written there, as long as the opcode in bits 27:26 is not 2.
- R3: A host write whose bits 27:26 equal 1 stores bits 15:0 into the PHY register selected by bits 25:21 (PHY) and 20:16 (register) of the written word.
- R4: While the stored bits 27:26 equal 2, the read word carries the addressed PHY register in bits 15:0. The upper bits are the stored ones, with bit 28 set.
- R5: PHY registers 1, 2, 3, 5, 6 and 17 always read 0x782C, 0x0013, 0x61D4, 0x41E1, 0x0001 and 0x4700, whatever was written to them.
- R6: PHY register 0 reads its stored value with bits 15 and 9 cleared and bit 13 set.
- R7: PHY addresses at or above NUM_PHY read 0 for every register, and writes to them change no emulated register.
- R8: Opcodes 0 and 3 in a host write change no PHY register.
- R9: When a host write and a host read fall in the same cycle, the read returns the word and PHY contents from before the write. The written word is the one kept, and the read-opcode refresh is discarded.
- R10: Separate PHY addresses keep separate register files; a write to one PHY leaves the same register of another PHY unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| host_wr | input | 1 | Host write strobe for the management word |
| host_wdata | input | 32 | Word to load |
| host_rd | input | 1 | Host read strobe; with a read opcode, refreshes the stored data field |
| host_rdata | output | 32 | Word as the host sees it (ready set, data from PHY for read opcode) |

## Verification
A host write and a host read can fall in the same cycle. Both touch the stored word, and the write may also change the very PHY register the read is fetching. The bench sets up a read opcode on PHY 0 register 4 first. In one cycle it then raises both strobes, with a write of a new value to that same register. The value sampled in that cycle must be the old register contents. After the edge, the word must be the written one, and a follow-up read opcode must show the new value.

// File: rtl/mdi_pkg.sv
package mdi_pkg;

    localparam int WORD_W   = 32;
    localparam int DATA_W   = 16;
    localparam int ADDR_W   = 5;
    localparam int NUM_REGS = 1 << ADDR_W;

    // Field positions of the management word
    localparam int POS_READY   = 28;
    localparam int POS_OP_LO   = 26;
    localparam int POS_PHY_LO  = 21;
    localparam int POS_REG_LO  = 16;

    typedef enum logic [1:0] {
        MGMT_OP_NONE  = 2'd0,
        MGMT_OP_WRITE = 2'd1,
        MGMT_OP_READ  = 2'd2,
        MGMT_OP_RSVD  = 2'd3
    } mgmt_op_e;

    typedef struct packed {
        logic [2:0]        top_bits;
        logic              ready;
        mgmt_op_e          op;
        logic [ADDR_W-1:0] phy;
        logic [ADDR_W-1:0] regn;
        logic [DATA_W-1:0] data;
    } mgmt_word_t;

    // Fixed readback values of the emulated PHY
    localparam logic [DATA_W-1:0] FIX_STATUS  = 16'h782C;
    localparam logic [DATA_W-1:0] FIX_ID_HI   = 16'h0013;
    localparam logic [DATA_W-1:0] FIX_ID_LO   = 16'h61D4;
    localparam logic [DATA_W-1:0] FIX_PARTNER = 16'h41E1;
    localparam logic [DATA_W-1:0] FIX_EXPAND  = 16'h0001;
    localparam logic [DATA_W-1:0] FIX_VENDOR  = 16'h4700;

    localparam logic [DATA_W-1:0] CTRL_CLEAR_MASK = 16'h8200;
    localparam logic [DATA_W-1:0] CTRL_FORCE_SET  = 16'h2000;

endpackage

// File: rtl/mdi_phy_bank.sv
module mdi_phy_bank
    import mdi_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);

    logic [DATA_W-1:0] regs_q [NUM_REGS];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_REGS; i++) begin
                regs_q[i] <= '0;
            end
        end else if (wr_en) begin
            regs_q[waddr] <= wdata;
        end
    end

    assign rdata = regs_q[raddr];

    // R3: a commit lands in the addressed entry
    assert_commit_lands_R3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> regs_q[$past(waddr)] == $past(wdata));

endmodule

// File: rtl/mdi_phy_view.sv
module mdi_phy_view
    import mdi_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              phy_valid,
    input  logic [ADDR_W-1:0] regn,
    input  logic [DATA_W-1:0] raw,
    output logic [DATA_W-1:0] shaped
);

    always_comb begin
        shaped = '0;
        if (phy_valid) begin
            unique case (regn)
                5'd0:    shaped = (raw & ~CTRL_CLEAR_MASK) | CTRL_FORCE_SET;
                5'd1:    shaped = FIX_STATUS;
                5'd2:    shaped = FIX_ID_HI;
                5'd3:    shaped = FIX_ID_LO;
                5'd5:    shaped = FIX_PARTNER;
                5'd6:    shaped = FIX_EXPAND;
                5'd17:   shaped = FIX_VENDOR;
                default: shaped = raw;
            endcase
        end
    end

    // R6: register 0 shaping
    assert_ctrl_shape_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (phy_valid && regn == '0) |-> (!shaped[15] && !shaped[9] && shaped[13]));

    // R7: unmodelled PHY reads zero
    assert_unmodelled_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !phy_valid |-> shaped == '0);

endmodule

// File: rtl/mdi_mgmt_reg.sv
module mdi_mgmt_reg
    import mdi_pkg::*;
#(
    parameter int NUM_PHY = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        host_wr,
    input  logic [31:0] host_wdata,
    input  logic        host_rd,
    output logic [31:0] host_rdata
);

    localparam int IDX_W = (NUM_PHY > 1) ? $clog2(NUM_PHY) : 1;

    mgmt_word_t ctrl_q;
    mgmt_word_t wr_word;

    logic [DATA_W-1:0] bank_rd [NUM_PHY];
    logic [DATA_W-1:0] raw_sel;
    logic [DATA_W-1:0] view_data;
    logic              rd_phy_valid;
    logic              wr_commit;
    logic              rd_refresh;
    logic [IDX_W-1:0]  rd_idx;

    assign wr_word      = mgmt_word_t'(host_wdata);
    assign wr_commit    = host_wr && (wr_word.op == MGMT_OP_WRITE);
    assign rd_phy_valid = (int'(ctrl_q.phy) < NUM_PHY);
    assign rd_idx       = IDX_W'(ctrl_q.phy);
    assign rd_refresh   = host_rd && !host_wr && (ctrl_q.op == MGMT_OP_READ);

    for (genvar g = 0; g < NUM_PHY; g++) begin : g_bank
        logic bank_we;
        assign bank_we = wr_commit && (int'(wr_word.phy) == g);

        mdi_phy_bank i_bank (
            .clk   (clk),
            .rst_n (rst_n),
            .wr_en (bank_we),
            .waddr (wr_word.regn),
            .wdata (wr_word.data),
            .raddr (ctrl_q.regn),
            .rdata (bank_rd[g])
        );
    end

    assign raw_sel = rd_phy_valid ? bank_rd[rd_idx] : '0;

    mdi_phy_view i_view (
        .clk       (clk),
        .rst_n     (rst_n),
        .phy_valid (rd_phy_valid),
        .regn      (ctrl_q.regn),
        .raw       (raw_sel),
        .shaped    (view_data)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else if (host_wr) begin
            ctrl_q <= wr_word;
        end else if (rd_refresh) begin
            ctrl_q.data <= view_data;
        end
    end

    always_comb begin
        host_rdata            = ctrl_q;
        host_rdata[POS_READY] = 1'b1;
        if (ctrl_q.op == MGMT_OP_READ) begin
            host_rdata[DATA_W-1:0] = view_data;
        end
    end

    // R2: the whole written word is kept
    assert_word_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        host_wr |=> ctrl_q == $past(host_wdata));

    // R4: a read strobe with read opcode keeps the fetched data
    assert_refresh_keeps_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rd_refresh |=> ctrl_q.data == $past(view_data));

    // R9: a read in the same cycle as a write does not disturb the written word
    assert_write_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && host_rd) |=> ctrl_q.data == $past(host_wdata[15:0]));

endmodule

// File: tb/test_mdi_mgmt_reg.sv
module test_mdi_mgmt_reg;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_wr = 1'b0;
    logic [31:0] host_wdata = '0;
    logic        host_rd = 1'b0;
    logic [31:0] host_rdata;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    mdi_mgmt_reg #(.NUM_PHY(2)) i_mdi_mgmt_reg (
        .clk        (clk),
        .rst_n      (rst_n),
        .host_wr    (host_wr),
        .host_wdata (host_wdata),
        .host_rd    (host_rd),
        .host_rdata (host_rdata)
    );

    function automatic logic [31:0] mk(input int op, input int phy, input int rg, input logic [15:0] d);
        return {4'b0000, 2'(op), 5'(phy), 5'(rg), d};
    endfunction

    localparam logic [31:0] RDY = 32'h1000_0000;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %08h expected %08h", tag, act, exp);
        end
    endtask

    task automatic do_write(input logic [31:0] w);
        @(negedge clk);
        host_wr    = 1'b1;
        host_wdata = w;
        @(negedge clk);
        host_wr    = 1'b0;
    endtask

    task automatic read_check(input string tag, input logic [31:0] exp);
        @(negedge clk);
        host_rd = 1'b1;
        #1;
        check(tag, host_rdata, exp);
        @(negedge clk);
        host_rd = 1'b0;
    endtask

    task automatic phy_expect(input string tag, input int phy, input int rg, input logic [15:0] v);
        do_write(mk(2, phy, rg, 16'h0000));
        read_check(tag, mk(2, phy, rg, v) | RDY);
    endtask

    task automatic t_reset;
        read_check("R1 word", RDY);
        phy_expect("R1 reg4", 0, 4, 16'h0000);
        phy_expect("R1 reg0", 0, 0, 16'h2000);
    endtask

    task automatic t_word_load;
        do_write(32'hE3FF_5A5A);
        read_check("R2 ready forced", 32'hF3FF_5A5A);
        do_write(32'h1000_0001);
        read_check("R2 ready kept", 32'h1000_0001);
    endtask

    task automatic t_write_read;
        do_write(mk(1, 0, 4, 16'hBEEF));
        read_check("R3 write word", mk(1, 0, 4, 16'hBEEF) | RDY);
        phy_expect("R4 read back", 0, 4, 16'hBEEF);
        do_write(mk(1, 1, 31, 16'h1234));
        phy_expect("R10 phy1", 1, 31, 16'h1234);
        phy_expect("R10 phy0 untouched", 0, 31, 16'h0000);
    endtask

    task automatic t_fixed;
        logic [15:0] vals [6] = '{16'h782C, 16'h0013, 16'h61D4, 16'h41E1, 16'h0001, 16'h4700};
        int          regs [6] = '{1, 2, 3, 5, 6, 17};
        for (int i = 0; i < 6; i++) begin
            do_write(mk(1, 0, regs[i], 16'hFFFF));
            phy_expect("R5 phy0 fixed", 0, regs[i], vals[i]);
        end
        phy_expect("R5 phy1 fixed", 1, 2, 16'h0013);
    endtask

    task automatic t_reg0;
        do_write(mk(1, 0, 0, 16'hFFFF));
        phy_expect("R6 ones", 0, 0, 16'h7DFF);
        do_write(mk(1, 0, 0, 16'h8200));
        phy_expect("R6 cleared", 0, 0, 16'h2000);
    endtask

    task automatic t_unmodelled;
        do_write(mk(1, 2, 4, 16'hAAAA));
        phy_expect("R7 phy2 reads 0", 2, 4, 16'h0000);
        phy_expect("R7 phy2 fixed reg 0", 2, 1, 16'h0000);
        phy_expect("R7 no alias to phy0", 0, 4, 16'hBEEF);
        do_write(mk(1, 31, 4, 16'h5555));
        phy_expect("R7 phy31 no alias", 1, 4, 16'h0000);
    endtask

    task automatic t_other_ops;
        do_write(mk(0, 0, 4, 16'h1111));
        do_write(mk(3, 0, 4, 16'h2222));
        phy_expect("R8 ops 0 and 3", 0, 4, 16'hBEEF);
    endtask

    task automatic t_collide;
        do_write(mk(2, 0, 4, 16'h0000));
        @(negedge clk);
        host_rd    = 1'b1;
        host_wr    = 1'b1;
        host_wdata = mk(1, 0, 4, 16'h7777);
        #1;
        check("R9 old value in collision", host_rdata, mk(2, 0, 4, 16'hBEEF) | RDY);
        @(negedge clk);
        host_rd = 1'b0;
        host_wr = 1'b0;
        read_check("R9 write kept", mk(1, 0, 4, 16'h7777) | RDY);
        phy_expect("R9 new value", 0, 4, 16'h7777);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset;
        t_word_load;
        t_write_read;
        t_fixed;
        t_reg0;
        t_unmodelled;
        t_other_ops;
        t_collide;
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(200000 * 4);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule